// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM. The bus can carry a read or a write on every clock, in any mix, with no idle cycle between a read and a following write. Address, control, byte enables and write data are all sampled on the rising clock edge. Write data follows its address by a fixed delay, which frees the bus slot that a read needs for its data. A static mode input picks one of two read paths. In flow-through mode the array output drives the data outputs directly. In pipelined mode an extra output register sits in the path, and the write data delay grows by one edge to match.

Each word holds two 9-bit bytes, and each byte has its own write enable. A burst counter steps the two low address bits in either linear or interleaved order. Three select inputs must all be high to start an access. An output enable gates the data outputs with no clock involved. When write parity checking is on, each enabled byte is checked against the even or odd polarity that has been selected. A read that hits a write whose data has not yet reached the array returns the merged new bytes.

Top module: `nbt_sram`

## Requirements
- R1: A command is started at a rising edge when `adv` is 0 and `sel_a`, `sel_b` and `sel_c` are all 1. When `adv` is 0 and any select is 0, that edge starts nothing: no write happens, no read data is driven, and any burst in progress ends.
- R2: In flow-through mode (`pipe_mode`=0), read data for a command sampled at edge n is driven in the cycle that follows edge n. In pipelined mode (`pipe_mode`=1) the same data is driven in the cycle that follows edge n+1. `q_en` is 1 exactly in those cycles while `oe` is 1.
- R3: Write data for a write command sampled at edge n is taken from `wdata` at edge n+1 in flow-through mode, and at edge n+2 in pipelined mode.
- R4: Reads and writes may start on consecutive edges in any order with no idle edge between them, and every command takes effect.
- R5: Bit `byte_en[b]` is sampled with the command and controls byte b, which is `wdata[9b+8:9b]`. A byte whose enable is 0 keeps its old contents.
- R6: A read to an address that has a write still waiting for its data returns the new data for the enabled bytes and the old data for the other bytes.
- R7: With `adv`=1 after a started command, each edge issues the next beat. In linear order (`burst_ilv`=0), beat k uses address bits [1:0] = (start + k) mod 4, and the upper address bits stay unchanged.
- R8: In interleaved order (`burst_ilv`=1), beat k uses address bits [1:0] = start XOR (k mod 4). The upper address bits stay unchanged.
- R9: A burst beat keeps the read/write direction of the command that started the burst and ignores `we`, `addr` and the selects. `adv`=1 with no burst active does nothing.
- R10: `oe`=0 forces `q_en` to 0 and `rdata` to zero at once, with no clock edge. Raising `oe` again restores the driven data in the same cycle.
- R11: A byte has a parity error when the XOR of its 9 bits differs from `par_odd`. `par_err` is 1 in the cycle after a write data edge if `par_chk` was 1 at that edge and at least one enabled byte had an error. Otherwise it is 0. The data is written either way.
- R12: While `rst_n` is low and right after it is released, `q_en` and `par_err` are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through; held static |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| sel_a | input | 1 | Select, active high |
| sel_b | input | 1 | Select, active high |
| sel_c | input | 1 | Select, active high |
| adv | input | 1 | 1 = advance the current burst |
| we | input | 1 | 1 = write command, 0 = read command |
| byte_en | input | NBYTES | Per-byte write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Delayed write data |
| par_chk | input | 1 | Enable write parity checking |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | DATA_W | Read data, zero when not driven |
| q_en | output | 1 | Data outputs driven |
| par_err | output | 1 | Registered write parity error |

## Verification
The bench runs in both read modes. It fills the whole array with back-to-back writes and reads it all back with back-to-back reads, which exposes any error in the write delay or the read latency. Alternating write-then-read on one address uses partial byte masks, so a missing or wrong-byte forwarding path returns old bytes. Bursts from all four start offsets in both orders, with more beats than the burst length, separate linear stepping from XOR stepping and catch a broken wrap. Deselect patterns, stray advance cycles, bad parity in enabled and masked bytes, and output-enable toggling in the middle of a cycle each isolate one control path.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  // Width of the burst beat counter (four beats per burst).
  localparam int BEAT_BITS = 2;

  // Low address bits of beat `step` of a burst that began at `start`.
  function automatic logic [BEAT_BITS-1:0] beat_lo(
    input logic [BEAT_BITS-1:0] start,
    input logic [BEAT_BITS-1:0] step,
    input logic                 ilv
  );
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/nbt_burst_ctl.sv
module nbt_burst_ctl #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_all,
  input  logic              adv,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] be,
  input  logic              ilv,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NBYTES-1:0] cmd_be,
  output logic              burst_act
);
  localparam int BB = nbt_pkg::BEAT_BITS;

  logic [ADDR_W-1:0] base_q;
  logic [BB-1:0]     beat_q;
  logic [BB-1:0]     beat_nx;
  logic              dir_q;
  logic [ADDR_W-1:0] cont_addr;

  assign beat_nx   = beat_q + 1'b1;
  assign cont_addr = {base_q[ADDR_W-1:BB], nbt_pkg::beat_lo(base_q[BB-1:0], beat_nx, ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      cmd_vld   <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_addr  <= '0;
      cmd_be    <= '0;
      base_q    <= '0;
      beat_q    <= '0;
      dir_q     <= 1'b0;
    end else begin
      cmd_be <= be;
      if (!adv) begin
        burst_act <= sel_all;
        cmd_vld   <= sel_all;
        if (sel_all) begin
          base_q   <= addr;
          beat_q   <= '0;
          dir_q    <= we;
          cmd_wr   <= we;
          cmd_addr <= addr;
        end
      end else begin
        cmd_vld <= burst_act;
        if (burst_act) begin
          beat_q   <= beat_nx;
          cmd_addr <= cont_addr;
          cmd_wr   <= dir_q;
        end
      end
    end
  end

endmodule

// File: rtl/nbt_late_write.sv
module nbt_late_write #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     cmd_vld,
  input  logic                     cmd_wr,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [NBYTES-1:0]        cmd_be,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     par_chk,
  input  logic                     par_odd,
  output logic                     wr_go,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [NBYTES-1:0]        wr_be,
  output logic                     par_err
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              s2_vld;
  logic [ADDR_W-1:0] s2_addr;
  logic [NBYTES-1:0] s2_be;
  logic [NBYTES-1:0] bad;

  function automatic logic [NBYTES-1:0] bad_bytes(
    input logic [DATA_W-1:0] d,
    input logic              odd
  );
    logic [NBYTES-1:0] m;
    for (int b = 0; b < NBYTES; b++) m[b] = (^d[b*BYTE_W +: BYTE_W]) != odd;
    return m;
  endfunction

  // Second staging slot, used only for the two-edge delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s2_vld  <= cmd_vld & cmd_wr;
      s2_addr <= cmd_addr;
      s2_be   <= cmd_be;
    end
  end

  assign wr_go   = pipe_mode ? s2_vld  : (cmd_vld & cmd_wr);
  assign wr_addr = pipe_mode ? s2_addr : cmd_addr;
  assign wr_be   = pipe_mode ? s2_be   : cmd_be;
  assign bad     = bad_bytes(wdata, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_err <= 1'b0;
    else        par_err <= par_chk & wr_go & (|(wr_be & bad));
  end

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_go,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && wr_be[b]) bank[wr_addr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rd_word[b*BYTE_W +: BYTE_W] = bank[rd_addr];
  end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     oe,
  input  logic                     rd_now,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NBYTES*BYTE_W-1:0] rd_word,
  input  logic                     wr_go,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     q_en
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_word;
  logic              pq_vld;
  logic [DATA_W-1:0] pq_data;
  logic              out_vld;
  logic [DATA_W-1:0] out_word;

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [NBYTES-1:0] take
  );
    logic [DATA_W-1:0] r;
    for (int b = 0; b < NBYTES; b++)
      r[b*BYTE_W +: BYTE_W] = take[b] ? new_w[b*BYTE_W +: BYTE_W] : old_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  // A write that commits on the same edge as the output register loads.
  assign fwd_hit  = wr_go && (wr_addr == rd_addr);
  assign fwd_word = merge_bytes(rd_word, wdata, fwd_hit ? wr_be : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_vld  <= 1'b0;
      pq_data <= '0;
    end else begin
      pq_vld  <= rd_now;
      pq_data <= fwd_word;
    end
  end

  assign out_vld  = pipe_mode ? pq_vld  : rd_now;
  assign out_word = pipe_mode ? pq_data : rd_word;
  assign q_en     = out_vld & oe;
  assign rdata    = q_en ? out_word : '0;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c,
  input  logic              adv,
  input  logic              we,
  input  logic [NBYTES-1:0] byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              par_chk,
  input  logic              par_odd,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              q_en,
  output logic              par_err
);
  // Named internal events, visible to the bound checker.
  logic              sel_all;
  logic              cmd_vld;
  logic              cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [NBYTES-1:0] cmd_be;
  logic              burst_act;
  logic              rd_now;
  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_be;
  logic [DATA_W-1:0] rd_word;

  assign sel_all = sel_a & sel_b & sel_c;
  assign rd_now  = cmd_vld & ~cmd_wr;

  nbt_burst_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_all(sel_all), .adv(adv), .we(we),
    .addr(addr), .be(byte_en), .ilv(burst_ilv),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .burst_act(burst_act)
  );

  nbt_late_write #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_lw (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .wdata(wdata), .par_chk(par_chk), .par_odd(par_odd),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be), .par_err(par_err)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be),
    .wdata(wdata), .rd_addr(cmd_addr), .rd_word(rd_word)
  );

  nbt_read_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe),
    .rd_now(rd_now), .rd_addr(cmd_addr), .rd_word(rd_word),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be), .wdata(wdata),
    .rdata(rdata), .q_en(q_en)
  );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              burst_ilv,
  input logic              sel_a,
  input logic              sel_b,
  input logic              sel_c,
  input logic              adv,
  input logic              we,
  input logic              oe,
  input logic              par_chk,
  input logic [DATA_W-1:0] rdata,
  input logic              q_en,
  input logic              par_err,
  input logic              cmd_vld,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              burst_act
);
  logic start_cmd;
  logic start_rd;
  assign start_cmd = !adv && sel_a && sel_b && sel_c;
  assign start_rd  = start_cmd && !we;

  // R1: deselected edge issues nothing
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !(sel_a && sel_b && sel_c)) |=> !cmd_vld);

  // R4: every started command is issued on the next cycle
  p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> cmd_vld);

  // R2: flow-through read drives one cycle after its edge
  p_ft_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(start_rd)) |-> (q_en == oe));

  // R2: pipelined read drives two cycles after its edge
  p_pl_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(start_rd, 2)) |-> (q_en == oe));

  // R10: output enable low silences the outputs
  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!q_en && rdata == '0));

  // R7: linear burst steps the low bits by one
  p_lin_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && burst_act && !burst_ilv) |=> (cmd_addr[1:0] == 2'($past(cmd_addr[1:0]) + 2'd1)));

  // R8: burst never leaves its aligned group of four
  p_burst_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && burst_act) |=> (cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2])));

  // R11: no parity flag when checking was off
  p_parity_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !par_chk |=> !par_err);

endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
  .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .adv(adv), .we(we), .oe(oe),
  .par_chk(par_chk), .rdata(rdata), .q_en(q_en), .par_err(par_err),
  .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .burst_act(burst_act)
);

// File: tb/test_nbt_sram.sv
module test_nbt_sram;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b0, burst_ilv = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic adv = 1'b0, we = 1'b0, oe = 1'b1;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic par_chk = 1'b0, par_odd = 1'b0;
  logic [DW-1:0] rdata;
  logic q_en, par_err;

  nbt_sram i_nbt_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .adv(adv), .we(we),
    .byte_en(byte_en), .addr(addr), .wdata(wdata), .par_chk(par_chk),
    .par_odd(par_odd), .oe(oe), .rdata(rdata), .q_en(q_en), .par_err(par_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;

  // Bench reference state
  logic [DW-1:0] mdl [DEPTH];
  bit            pm, g_ilv, g_chk, g_odd, g_oe;
  bit            b_act, b_dir;
  logic [AW-1:0] b_base;
  logic [1:0]    b_k;
  bit            p1_v, p2_v, prd_v, exp_v, exp_pe;
  logic [AW-1:0] p1_a, p2_a, prd_a;
  logic [NB-1:0] p1_be, p2_be;
  logic [DW-1:0] p1_d, p2_d, exp_d;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, want, $time);
    end
  endtask

  function automatic logic [DW-1:0] mkword(input int seed, input bit odd);
    logic [DW-1:0] w;
    for (int b = 0; b < NB; b++) begin
      logic [7:0] p;
      p = 8'(seed * 37 + b * 91 + 5);
      w[b*9 +: 9] = {(^p) ^ odd, p};
    end
    return w;
  endfunction

  function automatic bit byte_bad(input logic [8:0] x, input bit odd);
    return (^x) != odd;
  endfunction

  // One clock: drive at negedge, update reference at posedge, compare at next negedge.
  task automatic cyc(input logic [2:0] sels, input bit a, input bit w, input logic [AW-1:0] ad,
                     input logic [NB-1:0] be, input logic [DW-1:0] d, input string tag);
    bit dv, cv, cw;
    logic [AW-1:0] da, ca;
    logic [NB-1:0] dbe;
    logic [DW-1:0] dd;
    dv = pm ? p2_v : p1_v; da = pm ? p2_a : p1_a;
    dbe = pm ? p2_be : p1_be; dd = pm ? p2_d : p1_d;
    sel_a = sels[0]; sel_b = sels[1]; sel_c = sels[2];
    adv = a; we = w; addr = ad; byte_en = be; wdata = dv ? dd : '0;
    burst_ilv = g_ilv; par_chk = g_chk; par_odd = g_odd; oe = g_oe;
    @(posedge clk);
    if (dv) for (int b = 0; b < NB; b++) if (dbe[b]) mdl[da][b*9 +: 9] = dd[b*9 +: 9];
    exp_pe = g_chk && dv && ((dbe[0] && byte_bad(dd[8:0], g_odd)) || (dbe[1] && byte_bad(dd[17:9], g_odd)));
    cv = 0; cw = 0; ca = '0;
    if (!a) begin
      b_act = &sels;
      if (&sels) begin b_base = ad; b_k = 0; b_dir = w; cv = 1; cw = w; ca = ad; end
    end else if (b_act) begin
      b_k = b_k + 2'd1;
      ca = {b_base[AW-1:2], g_ilv ? (b_base[1:0] ^ b_k) : 2'(b_base[1:0] + b_k)};
      cv = 1; cw = b_dir;
    end
    if (pm) begin p2_v = p1_v; p2_a = p1_a; p2_be = p1_be; p2_d = p1_d; end
    p1_v = cv && cw; p1_a = ca; p1_be = be; p1_d = d;
    if (pm) begin
      exp_v = prd_v; exp_d = mdl[prd_a]; prd_v = cv && !cw; prd_a = ca;
    end else begin
      exp_v = cv && !cw; exp_d = mdl[ca];
    end
    @(negedge clk);
    check(tag, 32'(q_en), 32'(exp_v && g_oe));
    if (exp_v && g_oe) check(tag, 32'(rdata), 32'(exp_d));
    else               check(tag, 32'(rdata), 32'h0);
    check({tag, "/R11"}, 32'(par_err), 32'(exp_pe));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(3'b000, 0, 0, '0, '0, '0, tag);
  endtask

  task automatic do_reset(input bit mode);
    pm = mode; pipe_mode = mode;
    g_ilv = 0; g_chk = 0; g_odd = 0; g_oe = 1;
    sel_a = 0; sel_b = 0; sel_c = 0; adv = 0; we = 0; oe = 1;
    rst_n = 0;
    b_act = 0; p1_v = 0; p2_v = 0; prd_v = 0; exp_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset q_en", 32'(q_en), 32'h0);
    check("R12 reset par_err", 32'(par_err), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R12 after release", 32'(q_en), 32'h0);
  endtask

  task automatic oe_probe();
    if (exp_v) begin
      oe = 0; #1;
      check("R10 oe low q_en", 32'(q_en), 32'h0);
      check("R10 oe low rdata", 32'(rdata), 32'h0);
      oe = 1; #1;
      check("R10 oe high q_en", 32'(q_en), 32'h1);
      check("R10 oe high rdata", 32'(rdata), 32'(exp_d));
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      g_chk = 1;
      // full fill, back to back
      for (int a = 0; a < DEPTH; a++) cyc(3'b111, 0, 1, AW'(a), 2'b11, mkword(a + m * 100, 0), "R3");
      idle(3, "R3");
      // full readback, back to back
      for (int a = 0; a < DEPTH; a++) cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R2");
      idle(3, "R2");
      // write then immediate read of the same address, partial masks
      for (int a = 0; a < 16; a++) begin
        cyc(3'b111, 0, 1, AW'(a), 2'(a % 3 + 1), mkword(a + 300 + m, 0), "R5");
        cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R6");
      end
      // read-write-read on consecutive edges
      for (int a = 16; a < 28; a++) begin
        cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R4");
        cyc(3'b111, 0, 1, AW'(a), 2'b11, mkword(a + 400 + m, 0), "R4");
        cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R4");
      end
      idle(3, "R4");
      // partially deselected writes do nothing
      for (int s = 0; s < 3; s++) begin
        logic [2:0] sp;
        sp = 3'b111 & ~(3'b001 << s);
        cyc(sp, 0, 1, AW'(40), 2'b11, mkword(999, 0), "R1");
      end
      idle(3, "R1");
      cyc(3'b111, 0, 0, AW'(40), 2'b00, '0, "R1");
      idle(3, "R1");
      // bursts, both orders, all start offsets
      for (int il = 0; il < 2; il++) begin
        g_ilv = il[0];
        for (int st = 0; st < 4; st++) begin
          logic [AW-1:0] ba;
          string tg;
          tg = il ? "R8" : "R7";
          ba = AW'(32 + il * 16 + st * 5);
          cyc(3'b111, 0, 1, ba, 2'b11, mkword(500 + il * 40 + st * 8, 0), tg);
          for (int k = 1; k < 4; k++)
            cyc(3'b000, 1, 0, AW'(0), 2'b11, mkword(500 + il * 40 + st * 8 + k, 0), "R9");
          idle(2, tg);
          cyc(3'b111, 0, 0, ba, 2'b00, '0, tg);
          for (int k = 1; k < 6; k++) cyc(3'b000, 1, 1, AW'(0), 2'b00, '0, tg);
          idle(3, tg);
        end
      end
      g_ilv = 0;
      // advance with nothing active
      cyc(3'b011, 0, 0, AW'(3), 2'b00, '0, "R9");
      for (int k = 0; k < 3; k++) cyc(3'b111, 1, 1, AW'(3), 2'b11, mkword(7, 0), "R9");
      idle(3, "R9");
      // parity: even and odd, enabled and masked bytes, checking off
      for (int od = 0; od < 2; od++) begin
        g_odd = od[0]; g_chk = 1;
        cyc(3'b111, 0, 1, AW'(50), 2'b11, mkword(60, od[0]), "R11");
        cyc(3'b111, 0, 1, AW'(51), 2'b11, mkword(61, od[0]) ^ 18'h20000, "R11");
        cyc(3'b111, 0, 1, AW'(52), 2'b01, mkword(62, od[0]) ^ 18'h20000, "R11");
        cyc(3'b111, 0, 1, AW'(53), 2'b10, mkword(63, od[0]) ^ 18'h00001, "R11");
        idle(3, "R11");
        g_chk = 0;
        cyc(3'b111, 0, 1, AW'(54), 2'b11, mkword(64, od[0]) ^ 18'h00101, "R11");
        idle(3, "R11");
        for (int a = 50; a < 55; a++) cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R11");
        idle(3, "R11");
      end
      g_odd = 0;
      // output enable: mid-cycle toggles and a whole read with it low
      for (int a = 0; a < 4; a++) begin
        cyc(3'b111, 0, 0, AW'(a), 2'b00, '0, "R10");
        oe_probe();
        idle(1, "R10");
        oe_probe();
      end
      g_oe = 0;
      cyc(3'b111, 0, 0, AW'(5), 2'b00, '0, "R10");
      idle(2, "R10");
      g_oe = 1;
      idle(2, "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule